// File: doc/BRIEF.md
# Strided Write Traffic Engine

This block drives write traffic into a memory port so that write throughput can be measured. It sits on one AXI-style write port: an address channel, a data channel and a response channel. It runs on the same clock as the memory interface, so no clock-domain crossing sits in the data path. A task is loaded with one start pulse. The task gives a base address A, a transaction count N, a burst size B in bytes, a stride S in bytes and a working-set size W in bytes. The engine then issues N write bursts whose offsets step by S and wrap inside the power-of-two window W.

The address and data channels each follow valid/ready rules. Once the engine raises valid, it holds valid and the payload unchanged until the receiver returns ready. A cycle in which valid and ready are both high moves one item. The receiver may stall either channel for as long as it likes. The engine never drops valid between transfers while a task still has work on that channel, so the channel stays saturated. Completion is measured when the N-th write response is accepted, not when the N-th transfer is issued. The elapsed cycle count is then frozen, and together with N×B it gives the achieved bandwidth. Control pins (start, busy, done, error, elapsed) are plain levels.

The engine expects W to be a power of two larger than 16, and B and S to be powers of two with S ≤ W. B must be at least one data-bus width: 32 bytes with the default 256-bit bus, and 64 bytes when the engine is used with a 512-bit bus for DDR4.

Top module: `stride_wr_engine`

## Requirements
- R1: While reset is held and after it is released, busy, done, err, aw_valid and w_valid are 0 and elapsed is 0.
- R2: The address of the i-th burst (i counting from 0) is A + ((i × S) mod W), with the addition wrapping at the address width.
- R3: aw_len equals B / (DATA_W/8) − 1. Each burst carries exactly aw_len+1 data beats, and w_last is 1 only on the final beat.
- R4: From the cycle after a task is accepted until the address channel has moved N items, aw_valid stays high with no gap. The same holds for w_valid until N bursts have moved. While valid is high and ready is low, the payload of that channel is held stable.
- R5: A task moves exactly N address items and N bursts. After that, aw_valid and w_valid are 0.
- R6: busy falls and done rises at the clock edge that accepts the N-th write response, and no earlier, even when all transfers have already been issued. b_ready is always 1.
- R7: elapsed equals the number of clock edges from the edge that accepts the task up to and including the edge of the N-th response. It stays frozen after that until the next task.
- R8: A response code other than 0 (OKAY) sets err. err stays set for the rest of the task and is cleared when the next task is accepted.
- R9: A start pulse while busy is 1 is ignored. The running task's addresses, burst length and count are unchanged.
- R10: A task with N = 0 raises done at the accepting edge, leaves busy at 0, and sets elapsed to 0. No valid is raised.
- R11: Beat j of burst i carries on w_data the 32-bit word {i[15:0], j[15:0]} repeated across the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_start | input | 1 | Pulse to accept a task when idle |
| task_addr | input | ADDR_W | Base address A |
| task_count | input | CNT_W | Transaction count N |
| task_burst | input | SIZE_W | Burst size B in bytes |
| task_stride | input | SIZE_W | Stride S in bytes |
| task_window | input | SIZE_W | Working-set size W in bytes |
| busy | output | 1 | Task in progress |
| done | output | 1 | Last task finished |
| err | output | 1 | Sticky error-response flag |
| elapsed | output | CYC_W | Cycles from accept to last response |
| aw_valid | output | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| aw_addr | output | ADDR_W | Burst start address |
| aw_len | output | 8 | Beats per burst minus one |
| w_valid | output | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| w_data | output | DATA_W | Write beat payload |
| w_last | output | 1 | Final beat of a burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| b_resp | input | 2 | Write response code |

## Verification
The bench aims at the wrap of the offset. It uses a stride equal to the window, where every burst must hit the base address. It also uses a few bursts per window, where a sweep that skipped the mask would run past A+W. It holds all responses back until every transfer has moved. An engine that judged completion at issue would raise done too early there, with a short elapsed count. Random ready stalls catch a valid that drops, or a payload that moves, while a channel waits. The bench also covers an error response in the middle of a task, the next task clearing the flag, a zero-length task, and a start pulse during a busy task. A design that got these wrong would keep a stale err, hang or emit traffic on N = 0, or restart its sweep in the middle of a task.

// File: rtl/swe_pkg.sv
package swe_pkg;
  localparam int LEN_W = 8;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int TAG_W = 16;
endpackage

// File: rtl/swe_addr_seq.sv
module swe_addr_seq
  import swe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 32,
  parameter int CNT_W    = 32,
  parameter int BEAT_LOG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  logic [SIZE_W-1:0] burst_bytes,
  input  logic [SIZE_W-1:0] stride,
  input  logic [SIZE_W-1:0] window,
  input  logic              aw_ready,
  output logic              aw_valid,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [LEN_W-1:0]  aw_len,
  output logic [CNT_W-1:0]  left
);
  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] step_q;
  logic [SIZE_W-1:0] mask_q;
  logic [SIZE_W-1:0] offs_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  left_q;
  logic [SIZE_W-1:0] beats;
  logic              fire;

  assign beats    = burst_bytes >> BEAT_LOG;
  assign fire     = aw_valid && aw_ready;
  assign aw_valid = (left_q != '0);
  assign aw_addr  = base_q + ADDR_W'(offs_q);
  assign aw_len   = len_q;
  assign left     = left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      mask_q <= '0;
      offs_q <= '0;
      len_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      base_q <= base;
      step_q <= stride;
      mask_q <= window - SIZE_W'(1);
      offs_q <= '0;
      len_q  <= LEN_W'(beats - SIZE_W'(1));
      left_q <= count;
    end else if (fire) begin
      offs_q <= (offs_q + step_q) & mask_q;
      left_q <= left_q - CNT_W'(1);
    end
  end

  // R4
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len));

  // R2
  aw_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> ((aw_addr - base_q) <= ADDR_W'(mask_q)));
endmodule

// File: rtl/swe_beat_seq.sv
module swe_beat_seq
  import swe_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  count,
  input  logic [LEN_W-1:0]  len,
  input  logic              w_ready,
  output logic              w_valid,
  output logic              w_last,
  output logic [DATA_W-1:0] w_data,
  output logic [CNT_W-1:0]  left
);
  localparam int REP = DATA_W / 32;

  logic [CNT_W-1:0] left_q;
  logic [LEN_W-1:0] beat_q;
  logic [TAG_W-1:0] idx_q;
  logic [31:0]      word;
  logic             fire;

  assign w_valid = (left_q != '0);
  assign w_last  = (beat_q == len);
  assign fire    = w_valid && w_ready;
  assign word    = {idx_q, TAG_W'(beat_q)};
  assign left    = left_q;

  generate
    for (genvar k = 0; k < REP; k++) begin : g_rep
      assign w_data[k*32 +: 32] = word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      beat_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      left_q <= count;
      beat_q <= '0;
      idx_q  <= '0;
    end else if (fire) begin
      if (w_last) begin
        beat_q <= '0;
        idx_q  <= idx_q + TAG_W'(1);
        left_q <= left_q - CNT_W'(1);
      end else begin
        beat_q <= beat_q + LEN_W'(1);
      end
    end
  end

  // R4
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_last));

  // R3
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> beat_q <= len);
endmodule

// File: rtl/swe_resp_track.sv
module swe_resp_track
  import swe_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic [CNT_W-1:0] total,
  input  logic             b_valid,
  input  logic [1:0]       b_resp,
  output logic [CNT_W-1:0] got,
  output logic             last_hit,
  output logic             err
);
  logic [CNT_W-1:0] got_q;
  logic             err_q;
  logic             take;

  assign take     = active && b_valid;
  assign last_hit = take && (got_q == total - CNT_W'(1));
  assign got      = got_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_q <= '0;
      err_q <= 1'b0;
    end else if (load) begin
      got_q <= '0;
      err_q <= 1'b0;
    end else if (take) begin
      got_q <= got_q + CNT_W'(1);
      if (b_resp != RESP_OKAY) err_q <= 1'b1;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !load |=> err);
endmodule

// File: rtl/stride_wr_engine.sv
module stride_wr_engine
  import swe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int CNT_W  = 32,
  parameter int CYC_W  = 32,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_start,
  input  logic [ADDR_W-1:0] task_addr,
  input  logic [CNT_W-1:0]  task_count,
  input  logic [SIZE_W-1:0] task_burst,
  input  logic [SIZE_W-1:0] task_stride,
  input  logic [SIZE_W-1:0] task_window,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CYC_W-1:0]  elapsed,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [DATA_W-1:0] w_data,
  output logic              w_last,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [1:0]        b_resp
);
  localparam int BEAT_LOG = $clog2(DATA_W / 8);

  logic             busy_q;
  logic             done_q;
  logic [CYC_W-1:0] cyc_q;
  logic [CNT_W-1:0] n_q;
  logic             accept;
  logic             last_hit;
  logic [CNT_W-1:0] aw_left;
  logic [CNT_W-1:0] w_left;
  logic [CNT_W-1:0] resp_got;
  logic [LEN_W-1:0] len_w;

  assign accept  = task_start && !busy_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign elapsed = cyc_q;
  assign b_ready = 1'b1;
  assign aw_len  = 8'(len_w);

  swe_addr_seq #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .BEAT_LOG(BEAT_LOG)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .base(task_addr), .count(task_count), .burst_bytes(task_burst),
    .stride(task_stride), .window(task_window),
    .aw_ready(aw_ready), .aw_valid(aw_valid), .aw_addr(aw_addr),
    .aw_len(len_w), .left(aw_left)
  );

  swe_beat_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(accept), .count(task_count),
    .len(len_w), .w_ready(w_ready), .w_valid(w_valid), .w_last(w_last),
    .w_data(w_data), .left(w_left)
  );

  swe_resp_track #(.CNT_W(CNT_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .load(accept), .active(busy_q), .total(n_q),
    .b_valid(b_valid), .b_resp(b_resp), .got(resp_got),
    .last_hit(last_hit), .err(err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cyc_q  <= '0;
      n_q    <= '0;
    end else if (accept) begin
      n_q    <= task_count;
      cyc_q  <= '0;
      busy_q <= (task_count != '0);
      done_q <= (task_count == '0);
    end else if (busy_q) begin
      cyc_q <= cyc_q + CYC_W'(1);
      if (last_hit) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !aw_valid && !w_valid);

  // R6
  resp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, resp_got} + {1'b0, aw_left} <= {1'b0, n_q}) &&
               ({1'b0, resp_got} + {1'b0, w_left} <= {1'b0, n_q}));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R7
  elapsed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !accept |=> $stable(cyc_q));

  // R10
  zero_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && task_count == '0 |=> done_q && !busy_q && cyc_q == '0);
endmodule

// File: tb/sim_stride_wr_engine.sv
module sim_stride_wr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 256;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic task_start = 1'b0;
  logic [31:0] task_addr = '0, task_count = '0, task_burst = '0;
  logic [31:0] task_stride = '0, task_window = '0;
  logic busy, done, err, aw_valid, w_valid, w_last, b_ready;
  logic [31:0] elapsed, aw_addr;
  logic [7:0] aw_len;
  logic [DW-1:0] w_data;
  logic aw_ready = 1'b0, w_ready = 1'b0, b_valid = 1'b0;
  logic [1:0] b_resp = 2'b00;

  int checks = 0, fails = 0, edge_no = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_no <= edge_no + 1;

  stride_wr_engine u0 (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_addr(task_addr),
    .task_count(task_count), .task_burst(task_burst), .task_stride(task_stride),
    .task_window(task_window), .busy(busy), .done(done), .err(err),
    .elapsed(elapsed), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .aw_addr(aw_addr), .aw_len(aw_len), .w_valid(w_valid), .w_ready(w_ready),
    .w_data(w_data), .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready),
    .b_resp(b_resp)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint exp_addr(longint a, longint i, longint s, longint w);
    return (a + ((i * s) % w)) & 64'hFFFF_FFFF;
  endfunction

  function automatic logic [DW-1:0] exp_data(int i, int j);
    logic [31:0] wd = {i[15:0], j[15:0]};
    return {8{wd}};
  endfunction

  task automatic run_task(input longint a, input int n, input int b, input int s,
                          input int w, input int rdy_pct, input int err_at,
                          input bit hold_b, input bit poke);
    int aw_seen = 0, wl_seen = 0, b_sent = 0, beat = 0, start_edge, end_edge = 0;
    int gaps = 0, guard = 0, addr_bad = 0, data_bad = 0, len_bad = 0;
    bit poked = 0;
    longint bad_a = 0, bad_e = 0;
    int exp_len = b / (DW/8) - 1;
    @(negedge clk);
    task_addr = a[31:0]; task_count = n; task_burst = b;
    task_stride = s; task_window = w; task_start = 1'b1;
    start_edge = edge_no + 1;
    @(negedge clk);
    task_start = 1'b0;
    while (!done && guard < 40000) begin
      guard++;
      aw_ready = ($urandom % 100) < rdy_pct;
      w_ready  = ($urandom % 100) < rdy_pct;
      b_valid  = (b_sent < aw_seen && b_sent < wl_seen) &&
                 (!hold_b || (aw_seen == n && wl_seen == n)) &&
                 (($urandom % 100) < rdy_pct);
      b_resp   = (b_sent == err_at) ? 2'b10 : 2'b00;
      if (poke && !poked && aw_seen == 2) begin
        // R9: start pulse while busy, different parameters
        task_start = 1'b1; task_addr = 32'hDEAD_0000; task_count = 3;
        task_stride = 4096; task_window = 8192; task_burst = 256;
        poked = 1;
      end else task_start = 1'b0;
      #1;
      if ((aw_seen < n && !aw_valid) || (wl_seen < n && !w_valid)) gaps++;
      if (aw_valid && aw_ready) begin
        if (longint'(aw_addr) != exp_addr(a, aw_seen, s, w)) begin
          addr_bad++; bad_a = aw_addr; bad_e = exp_addr(a, aw_seen, s, w);
        end
        if (int'(aw_len) != exp_len) len_bad++;
        aw_seen++;
      end
      if (w_valid && w_ready) begin
        if (w_data != exp_data(wl_seen, beat)) data_bad++;
        if (w_last != (beat == exp_len)) len_bad++;
        if (w_last) begin wl_seen++; beat = 0; end else beat++;
      end
      if (b_valid && b_ready) begin
        b_sent++;
        if (b_sent == n) end_edge = edge_no + 1;
      end
      @(negedge clk);
    end
    task_start = 1'b0; b_valid = 1'b0;
    chk(addr_bad == 0, "R2 address sweep", bad_a, bad_e);
    chk(len_bad == 0, "R3 burst length / last", len_bad, 0);
    chk(data_bad == 0, "R11 beat payload", data_bad, 0);
    chk(gaps == 0, "R4 valid gaps", gaps, 0);
    chk(aw_seen == n && wl_seen == n, "R5 transfer count", aw_seen, n);
    chk(done && !busy && b_sent == n, "R6 done at last response", b_sent, n);
    chk(elapsed == 32'(end_edge - start_edge), "R7 elapsed", elapsed, end_edge - start_edge);
    chk(err == (err_at < n), "R8 error flag", err, err_at < n);
    aw_ready = 1'b1; w_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!aw_valid && !w_valid, "R5 quiet after task", aw_valid, 0);
    chk(elapsed == 32'(end_edge - start_edge), "R7 elapsed frozen", elapsed, end_edge - start_edge);
    aw_ready = 1'b0; w_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !err && !aw_valid && !w_valid && elapsed == 0, "R1 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !aw_valid && !w_valid && elapsed == 0, "R1 after release", done, 0);
    chk(b_ready == 1'b1, "R6 b_ready high", b_ready, 1);

    // R2 wrap every four bursts, full-rate readiness
    run_task(64'h1000, 8, 32, 64, 256, 100, 1000, 0, 0);
    // R2 stride equal to window: every burst at the base
    run_task(64'h2000, 5, 64, 128, 128, 100, 1000, 0, 0);
    // R8 error in the middle, random stalls, four-beat bursts
    run_task(64'h4000, 7, 128, 32, 512, 60, 3, 0, 0);
    // R8 cleared by next task; R6 responses held until all issued
    run_task(64'h8000, 6, 32, 32, 64, 80, 1000, 1, 0);
    // R9 start pulse ignored while busy
    run_task(64'hC000, 6, 64, 256, 1024, 70, 1000, 0, 1);

    // R10 zero-length task
    @(negedge clk);
    task_count = 0; task_start = 1'b1;
    @(negedge clk);
    task_start = 1'b0;
    chk(done && !busy && elapsed == 0 && !aw_valid && !w_valid, "R10 zero task", elapsed, 0);

    // random tasks
    for (int t = 0; t < 8; t++) begin
      int wl = 5 + int'($urandom % 8);
      int w = 1 << wl;
      int s = 1 << int'($urandom % (wl + 1));
      int b = 1 << (5 + int'($urandom % 3));
      int n = 1 + int'($urandom % 20);
      longint a = longint'($urandom % 65536) << 6;
      run_task(a, n, b, s, w, 30 + int'($urandom % 71), int'($urandom % 40), t[0], 0);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule